// File: doc/BRIEF.md
# Stack-Machine Arithmetic and Logic Unit

This unit computes the value that a 32-bit stack processor pushes back after an arithmetic, shift, logic or compare instruction. It sees the top of the data stack (operand B), the item beneath it (operand A) and the 8-bit instruction code. It returns one data word. It holds no state and has no clock, so a surrounding core samples the result in the same cycle that it presents the operands.

The opcode's upper nibble gives the instruction's stack effect. Codes 0x3_ are unary: they consume the top item and push one item, so they use B only. Codes 0x5_ are binary: they consume two items and push one. Results that are true or false follow the Forth convention. True is a word of all ones and false is zero, so a flag can be fed straight into AND, OR or a conditional branch. Any code that is not listed below yields zero.

Top module: `stk_alu`

## Requirements
- R1: Opcode 0x32 (logical inverse) returns all ones when B is zero and returns zero for any other B.
- R2: Opcode 0x33 returns B shifted left by one bit. Bit 0 of the result is zero.
- R3: Opcode 0x34 returns B shifted right by one bit. Bit 31 of the result is zero.
- R4: Opcode 0x35 returns B shifted right by one bit. Bit 31 of the result is a copy of bit 31 of B.
- R5: Opcode 0x51 returns A+B modulo 2^32.
- R6: Opcode 0x52 returns A-B modulo 2^32, where A is the second item and B is the top.
- R7: Opcodes 0x53, 0x54 and 0x55 return the bitwise AND, OR and XOR of A and B, in that order.
- R8: Opcode 0x56 returns all ones when A equals B and zero otherwise.
- R9: Opcode 0x57 returns all ones when A is greater than B, with both read as two's-complement signed numbers, and zero otherwise.
- R10: Opcode 0x58 returns all ones when A is less than B, with both read as signed numbers, and zero otherwise.
- R11: Opcode 0x59 returns the low 32 bits of A times B.
- R12: Every opcode not listed in R1 to R11 returns zero. This includes 0x30, 0x36, 0x50, 0x5A and codes outside the 0x3_ and 0x5_ groups.
- R13: The unary opcodes (0x32 to 0x35) ignore A. Their result depends on B alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Second stack item (operand A) |
| b_i | input | 32 | Top stack item (operand B) |
| op_i | input | 8 | Instruction code: upper nibble is the group, lower nibble selects the operation |
| res_o | output | 32 | Word to push back onto the stack |

## Verification
Every result is purely combinational. No register lies between the operands and `res_o`, so each result is due in the same cycle that the operands are applied. The bench drives new operands and a new opcode just after a rising clock edge. It samples `res_o` at the following falling edge, half a period later, after the inputs have settled and well before the next change. A full sweep of all 256 opcodes with zero operands confirms that only the two zero-sensitive truth operations produce a nonzero word. The vector table covers the sign boundaries where signed and unsigned ordering disagree, as well as products that overflow 32 bits.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;
  localparam int unsigned OP_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NOT  = 8'h32,
    OP_SHL  = 8'h33,
    OP_SHR  = 8'h34,
    OP_SHRA = 8'h35,
    OP_ADD  = 8'h51,
    OP_SUB  = 8'h52,
    OP_AND  = 8'h53,
    OP_OR   = 8'h54,
    OP_XOR  = 8'h55,
    OP_EQ   = 8'h56,
    OP_GT   = 8'h57,
    OP_LT   = 8'h58,
    OP_MUL  = 8'h59
  } alu_op_e;
endpackage

// File: rtl/stk_alu_unary.sv
// Single-operand group: truth inverse and one-bit shifts on the top item.
module stk_alu_unary
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    unique case (op_i)
      OP_NOT:  res_o = {DATA_W{(b_i == '0)}};
      OP_SHL:  res_o = {b_i[MSB-1:0], 1'b0};
      OP_SHR:  res_o = {1'b0, b_i[MSB:1]};
      OP_SHRA: res_o = {b_i[MSB], b_i[MSB:1]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/stk_alu_arith.sv
// Two-operand adder, subtractor and truncating multiplier.
module stk_alu_arith
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] sum, dif, prd;

  assign sum = a_i + b_i;
  assign dif = a_i - b_i;
  assign prd = a_i * b_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = sum;
      OP_SUB:  res_o = dif;
      OP_MUL:  res_o = prd;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/stk_alu_bitlog.sv
// Bitwise logic built as repeated per-bit cells.
module stk_alu_bitlog
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic sel_and, sel_or, sel_xor;

  assign sel_and = (op_i == OP_AND);
  assign sel_or  = (op_i == OP_OR);
  assign sel_xor = (op_i == OP_XOR);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign res_o[i] = (sel_and & (a_i[i] & b_i[i]))
                    | (sel_or  & (a_i[i] | b_i[i]))
                    | (sel_xor & (a_i[i] ^ b_i[i]));
  end
endmodule

// File: rtl/stk_alu_cmp.sv
// Comparators returning Forth truth words.
module stk_alu_cmp
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic eq, gt, lt, hit;

  assign eq = (a_i == b_i);
  assign gt = ($signed(a_i) > $signed(b_i));
  assign lt = ($signed(a_i) < $signed(b_i));

  always_comb begin
    unique case (op_i)
      OP_EQ:   hit = eq;
      OP_GT:   hit = gt;
      OP_LT:   hit = lt;
      default: hit = 1'b0;
    endcase
  end

  assign res_o = {DATA_W{hit}};
endmodule

// File: rtl/stk_alu.sv
// Each unit drives zero unless it owns op_i, so an OR tree merges them.
module stk_alu
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] un_res, ar_res, lg_res, cm_res;

  stk_alu_unary #(.DATA_W(DATA_W)) u_unary (
    .op_i (op_i),
    .b_i  (b_i),
    .res_o(un_res)
  );

  stk_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(ar_res)
  );

  stk_alu_bitlog #(.DATA_W(DATA_W)) u_bitlog (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(lg_res)
  );

  stk_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(cm_res)
  );

  assign res_o = un_res | ar_res | lg_res | cm_res;
endmodule

// File: rtl/stk_alu_chk.sv
module stk_alu_chk
  import stk_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] res_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic listed;
  logic is_flag_op;

  assign listed = (op_i inside {8'h32, 8'h33, 8'h34, 8'h35, 8'h51, 8'h52, 8'h53,
                                8'h54, 8'h55, 8'h56, 8'h57, 8'h58, 8'h59});
  assign is_flag_op = (op_i inside {8'h32, 8'h56, 8'h57, 8'h58});

  always_comb begin
    if (op_i == OP_NOT)
      a_r1_not_truth: assert ((res_o != '0) == (b_i == '0));
    if (op_i == OP_SHL)
      a_r2_shl_low_zero: assert (res_o[0] == 1'b0);
    if (op_i == OP_SHR)
      a_r3_shr_top_zero: assert (res_o[MSB] == 1'b0);
    if (op_i == OP_SHRA)
      a_r4_shra_sign: assert (res_o[MSB] == b_i[MSB]);
    if (op_i == OP_SUB)
      a_r6_sub_inverse: assert (DATA_W'(res_o + b_i) == a_i);
    if (op_i == OP_ADD)
      a_r5_add_inverse: assert (DATA_W'(res_o - b_i) == a_i);
    if (is_flag_op)
      a_r8_flag_word: assert (res_o == '0 || res_o == '1);
    if (op_i == OP_GT && a_i == b_i)
      a_r9_gt_irreflexive: assert (res_o == '0);
    if (op_i == OP_LT && a_i == b_i)
      a_r10_lt_irreflexive: assert (res_o == '0);
    if (!listed)
      a_r12_unlisted_zero: assert (res_o == '0);
  end
endmodule

bind stk_alu stk_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .op_i (op_i),
  .res_o(res_o)
);

// File: tb/stk_alu_tb.sv
`timescale 1ns/1ps
module stk_alu_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NVEC = 33;
  localparam int unsigned WDOG_CYC = 20000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [DATA_W-1:0] a, b, res;
  logic [7:0]        op;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  stk_alu #(.DATA_W(DATA_W)) u_dut (
    .a_i  (a),
    .b_i  (b),
    .op_i (op),
    .res_o(res)
  );

  // {req, op, a, b, expected}
  localparam logic [111:0] VEC [NVEC] = '{
    {8'd1,  8'h32, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF}, // R1
    {8'd1,  8'h32, 32'h0000_0000, 32'h0000_0005, 32'h0000_0000}, // R1
    {8'd1,  8'h32, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000}, // R1
    {8'd13, 8'h32, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF}, // R13
    {8'd2,  8'h33, 32'h0000_0000, 32'h8000_0001, 32'h0000_0002}, // R2
    {8'd2,  8'h33, 32'h0000_0000, 32'h1234_5678, 32'h2468_ACF0}, // R2
    {8'd13, 8'h33, 32'h0000_DEAD, 32'h0000_0001, 32'h0000_0002}, // R13
    {8'd3,  8'h34, 32'h0000_0000, 32'h8000_0001, 32'h4000_0000}, // R3
    {8'd3,  8'h34, 32'h0000_0000, 32'h0000_0003, 32'h0000_0001}, // R3
    {8'd4,  8'h35, 32'h0000_0000, 32'h8000_0001, 32'hC000_0000}, // R4
    {8'd4,  8'h35, 32'h0000_0000, 32'h7FFF_FFFE, 32'h3FFF_FFFF}, // R4
    {8'd5,  8'h51, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}, // R5
    {8'd5,  8'h51, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030}, // R5
    {8'd6,  8'h52, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE}, // R6
    {8'd6,  8'h52, 32'h0000_0100, 32'h0000_0001, 32'h0000_00FF}, // R6
    {8'd7,  8'h53, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000}, // R7
    {8'd7,  8'h54, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0}, // R7
    {8'd7,  8'h55, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0}, // R7
    {8'd8,  8'h56, 32'h0000_1234, 32'h0000_1234, 32'hFFFF_FFFF}, // R8
    {8'd8,  8'h56, 32'h0000_1234, 32'h0000_1235, 32'h0000_0000}, // R8
    {8'd9,  8'h57, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R9
    {8'd9,  8'h57, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}, // R9
    {8'd9,  8'h57, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000}, // R9
    {8'd10, 8'h58, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF}, // R10
    {8'd10, 8'h58, 32'h0000_0003, 32'h0000_0003, 32'h0000_0000}, // R10
    {8'd11, 8'h59, 32'h0001_0000, 32'h0001_0000, 32'h0000_0000}, // R11
    {8'd11, 8'h59, 32'hFFFF_FFFE, 32'h0000_0003, 32'hFFFF_FFFA}, // R11
    {8'd11, 8'h59, 32'h0000_1234, 32'h0000_0010, 32'h0001_2340}, // R11
    {8'd12, 8'h30, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000}, // R12
    {8'd12, 8'h50, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000}, // R12
    {8'd12, 8'h5A, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000}, // R12
    {8'd12, 8'h36, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000}, // R12
    {8'd12, 8'hD1, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000}  // R12
  };

  task automatic apply_check(input int req, input logic [7:0] o,
                             input logic [31:0] av, input logic [31:0] bv,
                             input logic [31:0] exp);
    @(posedge clk);
    #0.5;
    op = o; a = av; b = bv;
    @(negedge clk);
    total++;
    if (res !== exp) begin
      bad++;
      $display("FAIL R%0d op=%02h a=%08h b=%08h actual=%08h expected=%08h",
               req, o, av, bv, res, exp);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    // idle inputs give zero
    apply_check(12, 8'h00, 32'h0, 32'h0, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      apply_check(int'(VEC[i][111:104]), VEC[i][103:96], VEC[i][95:64],
                  VEC[i][63:32], VEC[i][31:0]);
    end

    // R12 / R1 / R8: sweep every code with zero operands
    for (int k = 0; k < 256; k++) begin
      logic [31:0] e;
      int rq;
      e  = (k == 8'h32 || k == 8'h56) ? 32'hFFFF_FFFF : 32'h0;
      rq = (k == 8'h32) ? 1 : (k == 8'h56) ? 8 : 12;
      apply_check(rq, 8'(k), 32'h0, 32'h0, e);
    end

    // R9 and R10 on the same pair: signed order, not unsigned
    apply_check(9,  8'h57, 32'h0000_0002, 32'hFFFF_FFFD, 32'hFFFF_FFFF);
    apply_check(10, 8'h58, 32'h0000_0002, 32'hFFFF_FFFD, 32'h0000_0000);
    // R13: A swept across extremes while B is fixed
    apply_check(13, 8'h35, 32'h0000_0000, 32'h8000_0000, 32'hC000_0000);
    apply_check(13, 8'h35, 32'hFFFF_FFFF, 32'h8000_0000, 32'hC000_0000);
    apply_check(13, 8'h34, 32'hA5A5_A5A5, 32'h0000_0002, 32'h0000_0001);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule